// File: doc/BRIEF.md
# Variable-Length Serial Transmit Buffer

This block is the transmit side of a synchronous serial unit. A host fills a small bank of byte-wide data registers through a byte-addressed write/read port. The block then hands the assembled word to a transmit shift register, which sends it one bit per serial clock strobe. A two-bit length code sets the frame size to 8, 16 or 32 bits. The code also sets how many of the byte registers belong to a frame. Byte register 0 always carries the least significant byte of the word.

A status output tells the host when the buffer can be refilled. It drops when the host writes the highest byte register that the current length uses. It rises again once that word has moved into the shift register. If the host refills the buffer while a frame is still shifting, the next frame follows with no idle bit between the two. A busy output covers the whole train of frames. The serial clock arrives as a single-cycle strobe that is synchronous to the block clock.

Top module: `vltx_buffer`

## Requirements
- R1: After reset, all four byte registers hold zero, `tx_empty` is 1, `tx_busy` is 0 and `sdo` is 0.
- R2: When an address is valid for the current length, a host write to it stores `host_wdata`. The value reads back on `host_rdata` in the same cycle that `host_addr` selects it, with no clock edge in between.
- R3: The length code picks the valid byte registers: code 00 gives an 8-bit frame from address 0; code 01 gives a 16-bit frame from addresses 0 and 1; code 10 gives a 32-bit frame from addresses 0 to 3.
- R4: Length code 11 is forbidden. While it is applied, every write is ignored, every read returns 0, and no frame is loaded even if a word is pending. The pending word starts once a legal code returns.
- R5: A write to an address above the top address of the current length leaves every register unchanged. A read of such an address returns 0.
- R6: A write to the top valid address (0, 1 or 3 for codes 00, 01, 10) clears `tx_empty` at that clock edge. A write to any other address leaves `tx_empty` unchanged.
- R7: When a word is pending and the shift register is idle, the next clock edge does three things. It copies the word into the shift register, sets `tx_empty` to 1 and raises `tx_busy`. After that edge `sdo` shows the frame's most significant bit.
- R8: Frame bits leave most significant first. Byte register 0 supplies the low byte of the frame. `sdo` moves to the next bit only on a clock edge where `shift_en` is 1, and holds otherwise.
- R9: Suppose a word is pending at the strobe that sends a frame's last bit. At that same edge the pending word loads, `tx_busy` stays 1, and `sdo` shows the new frame's most significant bit with no idle bit between the frames.
- R10: If nothing is pending, `tx_busy` falls and `sdo` returns to 0 at the strobe that sends the last bit.
- R11: The frame length is captured when the frame loads. Changing `len_code` while a frame shifts does not change how many bits that frame sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_code | input | 2 | Frame length code: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = forbidden |
| host_we | input | 1 | Host write strobe for one byte register |
| host_addr | input | 2 | Byte register address for both write and read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`; 0 when the address is not valid |
| shift_en | input | 1 | Serial clock strobe: one bit is sent per high cycle |
| tx_empty | output | 1 | 1 when the buffer may be written with the next word |
| tx_busy | output | 1 | 1 while any frame is being shifted out |
| sdo | output | 1 | Serial data out, most significant bit first |

## Verification
Each result is due at a fixed point after its stimulus:
- `host_rdata` is combinational and is sampled one nanosecond after the address changes.
- A write of the top byte clears `tx_empty` at the edge that captures it.
- The load follows at the very next edge, so `tx_busy`, the refilled `tx_empty` and the first `sdo` bit are all due one edge after the top-byte write.
- Each `shift_en` strobe moves `sdo` at the edge that samples the strobe.

The bench drives inputs just after a falling edge and checks outputs at the next falling edge. Every expectation therefore falls exactly one rising edge after its cause. Idle cycles without a strobe are inserted within frames to confirm that `sdo` holds.

// File: rtl/vltx_pkg.sv
package vltx_pkg;

    // Default geometry of the transmit buffer
    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_NUM_BYTES = 4;

    // Length codes as seen on the len_code port
    typedef enum logic [1:0] {
        LEN_8BIT  = 2'b00,
        LEN_16BIT = 2'b01,
        LEN_32BIT = 2'b10,
        LEN_BAD   = 2'b11
    } len_code_e;

    // Control state of the top level: pending-word flag
    typedef struct packed {
        logic full;
    } ctl_state_t;

endpackage

// File: rtl/vltx_regbank.sv
module vltx_regbank #(
    parameter int BYTE_W    = vltx_pkg::DEF_BYTE_W,
    parameter int NUM_BYTES = vltx_pkg::DEF_NUM_BYTES,
    localparam int ADDR_W   = $clog2(NUM_BYTES),
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W:0]   nvalid,   // number of bytes in use, 0 = none
    output logic [BYTE_W-1:0] rdata,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_BYTES-1:0] wr_hit;
    logic                 addr_ok;

    assign addr_ok = ({1'b0, addr} < nvalid);

    // Per-byte write decode: hit only when the byte is inside the frame
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_dec
        localparam logic [ADDR_W:0] IDX = (ADDR_W + 1)'(g);
        assign wr_hit[g] = we && (addr == IDX[ADDR_W-1:0]) && (IDX < nvalid);
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_hit[i]) begin
                bank_d.bytes[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            rdata = bank_q.bytes[addr];
        end
    end

    assign word = bank_q.bytes;

    // R4/R5: writes outside the active frame leave the bank untouched
    p_ignore_invalid_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !addr_ok) |=> $stable(word))
        else $error("write outside active length changed the bank");

    // R2: a valid write lands in the bank by the next cycle
    p_valid_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr_ok) |=> (bank_q.bytes[$past(addr)] == $past(wdata)))
        else $error("valid write not stored");

endmodule

// File: rtl/vltx_shifter.sv
module vltx_shifter #(
    parameter int WORD_W  = 32,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,   // left aligned frame
    input  logic [CNT_W-1:0]  load_bits,
    input  logic              shift_en,
    output logic              sdo,
    output logic              busy,
    output logic              last_bit
);

    typedef struct packed {
        logic [WORD_W-1:0] sreg;
        logic [CNT_W-1:0]  cnt;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sreg = load_word;
            sh_d.cnt  = load_bits;
        end else if (shift_en && (sh_q.cnt != '0)) begin
            sh_d.sreg = {sh_q.sreg[WORD_W-2:0], 1'b0};
            sh_d.cnt  = sh_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdo      = sh_q.sreg[WORD_W-1];
    assign busy     = (sh_q.cnt != '0);
    assign last_bit = (sh_q.cnt == CNT_W'(1));

    // R8: without a strobe or a load the frame holds still
    p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en && !load) |=> ($stable(sh_q.sreg) && $stable(busy)))
        else $error("shift register moved without a strobe");

    // R10: a frame train only ends on a strobe
    p_end_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(shift_en))
        else $error("busy fell without a strobe");

    // R9: a load never cuts a running frame short
    p_load_only_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy) |-> (last_bit && shift_en))
        else $error("load while frame still had bits to send");

endmodule

// File: rtl/vltx_buffer.sv
module vltx_buffer #(
    parameter int BYTE_W    = vltx_pkg::DEF_BYTE_W,
    parameter int NUM_BYTES = vltx_pkg::DEF_NUM_BYTES,
    localparam int ADDR_W   = $clog2(NUM_BYTES),
    localparam int WORD_W   = BYTE_W * NUM_BYTES,
    localparam int CNT_W    = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        len_code,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              shift_en,
    output logic              tx_empty,
    output logic              tx_busy,
    output logic              sdo
);
    import vltx_pkg::*;

    // Largest legal code: 2**code bytes must fit the bank
    localparam logic [1:0] MAX_CODE = 2'(ADDR_W);

    ctl_state_t ctl_d, ctl_q;

    logic              len_ok;
    logic [ADDR_W:0]   nvalid;
    logic              wr_top;
    logic              load;
    logic [WORD_W-1:0] bank_word;
    logic [WORD_W-1:0] frame_word;
    logic [CNT_W-1:0]  frame_bits;
    logic              sh_busy;
    logic              sh_last;

    // Length decode
    always_comb begin
        len_ok = (len_code <= MAX_CODE);
        nvalid = len_ok ? ((ADDR_W + 1)'(1) << len_code) : '0;
    end

    // Frame geometry: bit count and left alignment for MSB-first output
    always_comb begin
        frame_bits = CNT_W'(nvalid) * CNT_W'(BYTE_W);
        frame_word = bank_word << (CNT_W'(WORD_W) - frame_bits);
    end

    // Top-byte write marks the buffer full; a load drains it
    always_comb begin
        wr_top = host_we && (nvalid != '0) && ({1'b0, host_addr} == (nvalid - 1'b1));
        load   = ctl_q.full && len_ok && (!sh_busy || (sh_last && shift_en));
        ctl_d  = ctl_q;
        if (load) begin
            ctl_d.full = 1'b0;
        end
        if (wr_top) begin
            ctl_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    vltx_regbank #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (host_we),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .nvalid (nvalid),
        .rdata  (host_rdata),
        .word   (bank_word)
    );

    vltx_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (frame_word),
        .load_bits (frame_bits),
        .shift_en  (shift_en),
        .sdo       (sdo),
        .busy      (sh_busy),
        .last_bit  (sh_last)
    );

    assign tx_empty = !ctl_q.full;
    assign tx_busy  = sh_busy;

    // R4: a frame train never starts under the forbidden length code
    p_no_start_bad_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> ($past(len_code) != LEN_BAD))
        else $error("transfer started with forbidden length");

    // R6: the empty flag only drops because of a host write
    p_empty_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(host_we))
        else $error("empty flag cleared without a write");

    // R7: the empty flag only rises when a word enters the shifter
    p_empty_set_by_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> tx_busy)
        else $error("empty flag set without a load");

endmodule

// File: tb/tb_vltx_buffer.sv
module tb_vltx_buffer;
    import vltx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] len_code;
    logic       host_we;
    logic [1:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       shift_en;
    logic       tx_empty;
    logic       tx_busy;
    logic       sdo;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mdl [4];

    always #5 clk = ~clk;

    vltx_buffer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_code   (len_code),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .shift_en   (shift_en),
        .tx_empty   (tx_empty),
        .tx_busy    (tx_busy),
        .sdo        (sdo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] c);
        return (c == 2'b11) ? 0 : (1 << c);
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        host_we    = 1'b1;
        host_addr  = 2'(a);
        host_wdata = d;
        if (a < nb(len_code)) mdl[a] = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [7:0] exp;
        host_addr = 2'(a);
        #1;
        exp = (a < nb(len_code)) ? mdl[a] : 8'h00;
        chk(tag, host_rdata, exp);
    endtask

    task automatic fill(input logic [1:0] c, input logic [31:0] w);
        len_code = c;
        for (int i = 0; i < nb(c); i++) begin
            wr(i, w[8*i +: 8]);
            chk("R6 empty flag after byte write", tx_empty, (i == nb(c) - 1) ? 1'b0 : 1'b1);
        end
    endtask

    task automatic shift_bits(input logic [31:0] w, input int hi, input int lo, input string tag);
        for (int i = hi; i >= lo; i--) begin
            chk(tag, sdo, w[i]);
            if (i % 5 == 0) begin
                @(negedge clk);
                chk("R8 sdo holds without strobe", sdo, w[i]);
            end
            shift_en = 1'b1;
            @(negedge clk);
            shift_en = 1'b0;
        end
    endtask

    task automatic start_chk(input logic [31:0] w, input int bits);
        @(negedge clk);
        chk("R7 busy after load", tx_busy, 1'b1);
        chk("R7 empty after load", tx_empty, 1'b1);
        chk("R7 first bit is MSB", sdo, w[bits-1]);
    endtask

    task automatic end_chk(input string tag);
        chk({tag, " busy low"}, tx_busy, 1'b0);
        chk({tag, " sdo idle"}, sdo, 1'b0);
    endtask

    function automatic logic [31:0] pat(input int p, input int c);
        case (p)
            0:       return 32'hFFFF_FFFF;
            1:       return 32'h0000_0000;
            2:       return 32'h8000_0001 << c;
            default: return 32'h9E37_79B9 * (p * 3 + c + 1);
        endcase
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] wa, wb;
        rst_n      = 1'b0;
        len_code   = LEN_32BIT;
        host_we    = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
        shift_en   = 1'b0;
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 tx_empty", tx_empty, 1'b1);
        chk("R1 tx_busy", tx_busy, 1'b0);
        chk("R1 sdo", sdo, 1'b0);
        for (int a = 0; a < 4; a++) rd_chk(a, "R1 byte register zero");

        // R2 R3 R7 R8 R10: sweep lengths and patterns
        for (int c = 0; c < 3; c++) begin
            for (int p = 0; p < 6; p++) begin
                wa = pat(p, c);
                fill(2'(c), wa);
                chk("R7 not busy before load", tx_busy, 1'b0);
                start_chk(wa, 8 * nb(2'(c)));
                shift_bits(wa, 8 * nb(2'(c)) - 1, 0, "R8 R3 frame bit");
                end_chk("R10");
                chk("R10 empty stays set", tx_empty, 1'b1);
                for (int a = 0; a < 4; a++) rd_chk(a, "R2 R3 R5 readback");
            end
        end

        // R5: write beyond the active length is ignored
        len_code = LEN_8BIT;
        wr(3, 8'h77);
        chk("R5 empty unchanged", tx_empty, 1'b1);
        chk("R5 no transfer", tx_busy, 1'b0);
        rd_chk(3, "R5 invalid read zero");
        len_code = LEN_32BIT;
        rd_chk(3, "R5 byte 3 unchanged");

        // R11: length change during a frame does not shorten it
        wa = 32'hC3A5_1E69;
        fill(LEN_32BIT, wa);
        start_chk(wa, 32);
        shift_bits(wa, 31, 22, "R11 frame bit");
        len_code = LEN_8BIT;
        shift_bits(wa, 21, 0, "R11 frame bit after length change");
        end_chk("R11");

        // R9: back-to-back 16-bit frames
        wa = 32'h0000_B24D;
        wb = 32'h0000_6A93;
        fill(LEN_16BIT, wa);
        start_chk(wa, 16);
        shift_bits(wa, 15, 8, "R9 first frame bit");
        fill(LEN_16BIT, wb);
        shift_bits(wa, 7, 1, "R9 first frame bit");
        chk("R9 last bit of first frame", sdo, wa[0]);
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        chk("R9 busy stays high", tx_busy, 1'b1);
        chk("R9 next MSB without gap", sdo, wb[15]);
        chk("R9 empty set on load", tx_empty, 1'b1);
        shift_bits(wb, 15, 0, "R9 second frame bit");
        end_chk("R9");

        // R4: forbidden length blocks writes, reads and the pending load
        wa = 32'h1234_5678;
        wb = 32'hF00D_4B1D;
        fill(LEN_32BIT, wa);
        start_chk(wa, 32);
        shift_bits(wa, 31, 1, "R4 frame bit");
        fill(LEN_32BIT, wb);
        len_code = LEN_BAD;
        for (int a = 0; a < 4; a++) wr(a, 8'hA5);
        for (int a = 0; a < 4; a++) rd_chk(a, "R4 read under forbidden code");
        chk("R4 last bit", sdo, wa[0]);
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        end_chk("R4 no load under forbidden code");
        chk("R4 word still pending", tx_empty, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 still idle", tx_busy, 1'b0);
        len_code = LEN_32BIT;
        for (int a = 0; a < 4; a++) rd_chk(a, "R4 ignored writes left bank");
        start_chk(wb, 32);
        shift_bits(wb, 31, 0, "R4 pending frame bit");
        end_chk("R4");

        finish_run();
    end

endmodule